// File: doc/BRIEF.md
# PC Card Memory Cycle Controller

This block sits on the host side of a PC Card socket. It turns one host request at a time into a 16-bit memory cycle on the card. A request carries a 26-bit card address, a direction, a flag that picks attribute or common memory, a two-bit byte-lane code and write data. The controller drives the card address, the two active-low card enables and the active-low register-select line. It then strobes output-enable for a read or write-enable for a write, and it drives the shared data bus only while a write strobe is active.

A cycle runs through four phases. First the controller waits until the card reports ready. Next comes one setup clock with the address, the enables and register-select valid. Then the strobe is held for a host-programmed number of clocks, and it is stretched by every clock in which the card pulls its wait line low. Read data is captured on the last strobe clock. A final hold clock keeps address and enables stable before they are released. A one-clock done pulse follows the hold clock, and the captured read data stays on `rdata_o` until the next read completes.

Top module: `cardmem_ctrl`

## Requirements
- R1: Byte-lane code bit 0 selects the low lane (D0..D7) and drives `card_ce1_no` low; bit 1 selects the high lane (D8..D15) and drives `card_ce2_no` low; code 2'b11 is a full 16-bit cycle. Outside a cycle both enables are high.
- R2: `card_reg_no` is low for the whole cycle when `req_attr_i` is 1 (attribute memory) and high when it is 0 (common memory).
- R3: Address, enables and register-select are valid one clock before the strobe falls and one clock after it rises. Output-enable and write-enable are never low together.
- R4: The strobe stays low for max(`strb_len_i`,1) clocks plus one clock for every strobe clock in which `card_wait_ni` is sampled low.
- R5: A read pulses `card_oe_no`. `rdata_o` is loaded on the last strobe clock with the bus value, and unselected lanes are forced to zero. `rdata_o` is unchanged by writes.
- R6: A write pulses `card_we_no`. `req_wdata_i` is on `card_data_io` during every write-strobe clock, and the bus is released at all other times.
- R7: While `card_ready_i` is low, a pending cycle does not start. It starts, with setup, on the clock after ready is seen high.
- R8: A request with lane code 2'b00 causes no enable or strobe activity, and `done_o` pulses two clocks after the request is taken.
- R9: `done_o` is a single-clock pulse in the clock after the hold clock.
- R10: `req_i` is ignored while a cycle is in progress.
- R11: `card_addr_o` equals the 26-bit request address throughout the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request pulse, taken only when idle |
| req_addr_i | input | 26 | Card address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_attr_i | input | 1 | 1 = attribute memory, 0 = common memory |
| req_lanes_i | input | 2 | Byte-lane code: bit 0 = low lane, bit 1 = high lane |
| req_wdata_i | input | 16 | Write data |
| strb_len_i | input | 4 | Base strobe length in clocks (0 is treated as 1) |
| rdata_o | output | 16 | Last read data, unselected lanes zero |
| done_o | output | 1 | One-clock completion pulse |
| card_addr_o | output | 26 | Card address lines |
| card_ce1_no | output | 1 | Low-lane card enable, active low |
| card_ce2_no | output | 1 | High-lane card enable, active low |
| card_reg_no | output | 1 | Register select, low = attribute memory |
| card_oe_no | output | 1 | Read strobe, active low |
| card_we_no | output | 1 | Write strobe, active low |
| card_data_io | inout | 16 | Card data bus |
| card_wait_ni | input | 1 | Wait from card, active low |
| card_ready_i | input | 1 | Card ready, low = busy |

## Verification
The bench builds the controller with its default widths: a 26-bit address and a 4-bit strobe-length field. This lets random addresses reach the top address bit. It programs strobe lengths from 0 to 4 together with 0 to 3 injected wait clocks, so the length clamp and the wait stretch are both exercised, and their sum is checked against the measured strobe width. Holding ready low for several clocks, issuing a second request in the middle of a strobe and using lane code 2'b00 bring the start gating, the ignored request and the empty cycle within reach.

// File: rtl/cardmem_pkg.sv
package cardmem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_SETUP,
    ST_STRB,
    ST_HOLD
  } seq_state_e;

  localparam int LANE_BITS = 8;
endpackage

// File: rtl/cardmem_seq.sv
module cardmem_seq
  import cardmem_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          lanes_nz_i,
  input  logic          ready_i,
  input  logic          wait_ni,
  input  logic [LW-1:0] len_i,
  output logic          accept_o,
  output logic          capture_o,
  output logic          done_o,
  output seq_state_e    state_o
);
  seq_state_e    state_q, state_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          done_q;
  logic [LW-1:0] len_eff;

  assign len_eff   = (len_i == '0) ? LW'(1) : len_i;
  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign capture_o = (state_q == ST_STRB) && wait_ni && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_PEND;
      ST_PEND: begin
        if (!lanes_nz_i)  state_d = ST_IDLE;
        else if (ready_i) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        state_d = ST_STRB;
        cnt_d   = len_eff - LW'(1);
      end
      ST_STRB: begin
        // wait low freezes the count
        if (wait_ni) begin
          if (cnt_q == '0) state_d = ST_HOLD;
          else             cnt_d   = cnt_q - LW'(1);
        end
      end
      ST_HOLD:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= (state_q == ST_HOLD) || ((state_q == ST_PEND) && !lanes_nz_i);
    end
  end

  assign done_o  = done_q;
  assign state_o = state_q;
endmodule

// File: rtl/cardmem_lanes.sv
module cardmem_lanes
  import cardmem_pkg::*;
#(
  parameter int NL = 2,
  localparam int DW = NL * LANE_BITS
) (
  input  logic          active_i,
  input  logic [NL-1:0] lanes_i,
  output logic [NL-1:0] ce_no,
  output logic [DW-1:0] rmask_o,
  output logic          any_o
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign ce_no[g] = !(active_i && lanes_i[g]);
    assign rmask_o[g*LANE_BITS +: LANE_BITS] = {LANE_BITS{lanes_i[g]}};
  end
  assign any_o = |lanes_i;
endmodule

// File: rtl/cardmem_dbus.sv
module cardmem_dbus #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic          is_read_i,
  input  logic [DW-1:0] rmask_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rdata_q <= '0;
    else if (capture_i && is_read_i) rdata_q <= bus_i & rmask_i;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/cardmem_ctrl.sv
module cardmem_ctrl
  import cardmem_pkg::*;
#(
  parameter int AW = 26,
  parameter int LW = 4,
  localparam int NL = 2,
  localparam int DW = NL * LANE_BITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_we_i,
  input  logic          req_attr_i,
  input  logic [NL-1:0] req_lanes_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [LW-1:0] strb_len_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic [AW-1:0] card_addr_o,
  output logic          card_ce1_no,
  output logic          card_ce2_no,
  output logic          card_reg_no,
  output logic          card_oe_no,
  output logic          card_we_no,
  inout  wire  [DW-1:0] card_data_io,
  input  logic          card_wait_ni,
  input  logic          card_ready_i
);
  logic [AW-1:0] addr_q;
  logic          we_q, attr_q;
  logic [NL-1:0] lanes_q;
  logic [DW-1:0] wdata_q;
  logic [LW-1:0] len_q;

  logic          accept, capture, lanes_nz, active, strb, drv_en;
  logic [NL-1:0] ce_n;
  logic [DW-1:0] rmask;
  seq_state_e    state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      attr_q  <= 1'b0;
      lanes_q <= '0;
      wdata_q <= '0;
      len_q   <= '0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      we_q    <= req_we_i;
      attr_q  <= req_attr_i;
      lanes_q <= req_lanes_i;
      wdata_q <= req_wdata_i;
      len_q   <= strb_len_i;
    end
  end

  cardmem_seq #(.LW(LW)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .lanes_nz_i (lanes_nz),
    .ready_i    (card_ready_i),
    .wait_ni    (card_wait_ni),
    .len_i      (len_q),
    .accept_o   (accept),
    .capture_o  (capture),
    .done_o     (done_o),
    .state_o    (state)
  );

  assign active = (state == ST_SETUP) || (state == ST_STRB) || (state == ST_HOLD);
  assign strb   = (state == ST_STRB);

  cardmem_lanes #(.NL(NL)) i_lanes (
    .active_i (active),
    .lanes_i  (lanes_q),
    .ce_no    (ce_n),
    .rmask_o  (rmask),
    .any_o    (lanes_nz)
  );

  cardmem_dbus #(.DW(DW)) i_dbus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .is_read_i (!we_q),
    .rmask_i   (rmask),
    .bus_i     (card_data_io),
    .rdata_o   (rdata_o)
  );

  assign drv_en       = strb && we_q;
  assign card_data_io = drv_en ? wdata_q : {DW{1'bz}};

  assign card_addr_o = addr_q;
  assign card_ce1_no = ce_n[0];
  assign card_ce2_no = ce_n[1];
  assign card_reg_no = active ? !attr_q : 1'b1;
  assign card_oe_no  = !(strb && !we_q);
  assign card_we_no  = !(strb && we_q);
endmodule

// File: rtl/cardmem_ctrl_chk.sv
module cardmem_ctrl_chk #(
  parameter int AW = 26
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] card_addr_o,
  input logic          card_ce1_no,
  input logic          card_ce2_no,
  input logic          card_reg_no,
  input logic          card_oe_no,
  input logic          card_we_no,
  input logic          card_ready_i,
  input logic          done_o,
  input logic          drv_en
);
  logic strb_n, ce_on;
  assign strb_n = card_oe_no && card_we_no;
  assign ce_on  = !(card_ce1_no && card_ce2_no);

  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!card_oe_no && !card_we_no));

  p_setup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb_n) |-> $past(ce_on));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strb_n) |-> ce_on);

  p_strobe_ce_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strb_n |-> ce_on);

  p_addr_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_n && $past(!strb_n)) |->
      ($stable(card_addr_o) && $stable(card_reg_no) &&
       $stable(card_ce1_no) && $stable(card_ce2_no)));

  p_ready_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb_n) |-> $past(card_ready_i, 2));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_drive_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en |-> !card_we_no);

  p_read_nodrive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !card_oe_no |-> !drv_en);
endmodule

bind cardmem_ctrl cardmem_ctrl_chk #(.AW(AW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .card_addr_o  (card_addr_o),
  .card_ce1_no  (card_ce1_no),
  .card_ce2_no  (card_ce2_no),
  .card_reg_no  (card_reg_no),
  .card_oe_no   (card_oe_no),
  .card_we_no   (card_we_no),
  .card_ready_i (card_ready_i),
  .done_o       (done_o),
  .drv_en       (drv_en)
);

// File: tb/test_cardmem_ctrl.sv
`timescale 1ns/1ps
module test_cardmem_ctrl;
  localparam int AW = 26;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_we = 1'b0, req_attr = 1'b0;
  logic [1:0]    req_lanes = '0;
  logic [15:0]   req_wdata = '0;
  logic [LW-1:0] strb_len = '0;
  logic [15:0]   rdata;
  logic          done;
  logic [AW-1:0] card_addr;
  logic          ce1_n, ce2_n, reg_n, oe_n, we_n;
  wire  [15:0]   card_data;
  logic          wait_n = 1'b1;
  logic          ready = 1'b1;

  int tests = 0;
  int fails = 0;
  logic [15:0] last_rd = '0;

  always #4 clk = ~clk;

  cardmem_ctrl #(.AW(AW), .LW(LW)) i_cardmem_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_i        (req),
    .req_addr_i   (req_addr),
    .req_we_i     (req_we),
    .req_attr_i   (req_attr),
    .req_lanes_i  (req_lanes),
    .req_wdata_i  (req_wdata),
    .strb_len_i   (strb_len),
    .rdata_o      (rdata),
    .done_o       (done),
    .card_addr_o  (card_addr),
    .card_ce1_no  (ce1_n),
    .card_ce2_no  (ce2_n),
    .card_reg_no  (reg_n),
    .card_oe_no   (oe_n),
    .card_we_no   (we_n),
    .card_data_io (card_data),
    .card_wait_ni (wait_n),
    .card_ready_i (ready)
  );

  function automatic logic [15:0] card_pat(logic [AW-1:0] a, logic attr);
    return a[15:0] ^ 16'h5A3C ^ {attr, 6'd0, a[AW-1:AW-9]};
  endfunction

  function automatic logic [15:0] lane_mask(logic [1:0] l);
    return {{8{l[1]}}, {8{l[0]}}};
  endfunction

  // card model drives the bus during read strobes
  assign card_data = (!oe_n && we_n) ? card_pat(card_addr, !reg_n) : 16'hzzzz;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic [AW-1:0] a, input logic w, input logic at,
                         input logic [1:0] ln, input logic [15:0] wd,
                         input logic [LW-1:0] len, input int nwait,
                         input int rdy_at, input bit poke);
    int ce_first = 0, st_first = 0, st_last = 0, st_cnt = 0, done_n = 0;
    int wleft = 0, eff;
    bit hold_ok = 1'b0, lane_ok = 1'b1, reg_ok = 1'b1, addr_ok = 1'b1;
    bit wd_ok = 1'b1, prev_st = 1'b0, strobe_ok = 1'b1, extra = 1'b0;
    eff = (len == 0) ? 1 : int'(len);
    req_addr = a; req_we = w; req_attr = at; req_lanes = ln;
    req_wdata = wd; strb_len = len; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int n = 1; n < 400; n++) begin
      bit st, ca;
      st = !(oe_n && we_n);
      ca = !(ce1_n && ce2_n);
      if (ca && ce_first == 0) ce_first = n;
      if (st) begin
        if (st_first == 0) begin
          st_first = n;
          wleft = nwait;
          if (poke) begin
            req = 1'b1; req_addr = ~a; req_lanes = 2'b11;
          end
        end else if (poke) req = 1'b0;
        st_cnt++; st_last = n;
        if ({ce2_n, ce1_n} != ~ln) lane_ok = 1'b0;
        if (reg_n != !at) reg_ok = 1'b0;
        if (card_addr != a) addr_ok = 1'b0;
        if (w && card_data != wd) wd_ok = 1'b0;
        if (w ? (we_n || !oe_n) : (oe_n || !we_n)) strobe_ok = 1'b0;
        if (wleft > 0) begin wait_n = 1'b0; wleft--; end
        else wait_n = 1'b1;
      end else begin
        wait_n = 1'b1;
        if (prev_st) hold_ok = ca && ({ce2_n, ce1_n} == ~ln) && !done && (reg_n == !at);
      end
      prev_st = st;
      if (done) begin done_n = n; break; end
      if (n == rdy_at) ready = 1'b1;
      @(negedge clk);
    end
    req = 1'b0;
    if (ln == 2'b00) begin
      chk(done_n == 2, "R8 done timing for empty lanes", done_n, 2);
      chk(ce_first == 0 && st_cnt == 0, "R8 no card activity", st_cnt, 0);
    end else begin
      chk(ce_first == rdy_at + 1, "R7 setup start after ready", ce_first, rdy_at + 1);
      chk(st_first == ce_first + 1, "R3 one setup clock", st_first, ce_first + 1);
      chk(st_cnt == eff + nwait && st_last - st_first + 1 == st_cnt,
          "R4 strobe width", st_cnt, eff + nwait);
      chk(lane_ok, "R1 lane enables", {ce2_n, ce1_n}, ~ln);
      chk(reg_ok, "R2 register select", reg_n, !at);
      chk(addr_ok, "R11 card address", card_addr, a);
      chk(strobe_ok, w ? "R6 write strobe" : "R5 read strobe", oe_n, we_n);
      chk(hold_ok, "R3 hold clock", hold_ok, 1);
      chk(done_n == st_last + 2, "R9 done timing", done_n, st_last + 2);
      if (w) chk(wd_ok, "R6 write data on bus", wd_ok, 1);
    end
    @(negedge clk);
    chk(!done, "R9 done single clock", done, 0);
    if (!w && ln != 2'b00) last_rd = card_pat(a, at) & lane_mask(ln);
    chk(rdata == last_rd, "R5 read data", rdata, last_rd);
    if (poke) begin
      for (int k = 0; k < 8; k++) begin
        if (!(ce1_n && ce2_n) || done) extra = 1'b1;
        @(negedge clk);
      end
      chk(!extra, "R10 request during cycle ignored", extra, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h00C0FFEE));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce1_n && ce2_n && oe_n && we_n && reg_n, "R1 idle lines high after reset",
        {ce1_n, ce2_n, oe_n, we_n, reg_n}, 5'h1f);
    chk(!done && rdata == 16'h0, "R9 reset outputs quiet", rdata, 0);

    // directed corners
    run_txn(26'h3FF_FFFF, 1'b0, 1'b0, 2'b11, 16'h0, 4'd1, 0, 1, 1'b0);
    run_txn(26'h000_1234, 1'b0, 1'b1, 2'b01, 16'h0, 4'd0, 0, 1, 1'b0);
    run_txn(26'h200_0010, 1'b0, 1'b0, 2'b10, 16'h0, 4'd3, 2, 1, 1'b0);
    run_txn(26'h155_5555, 1'b1, 1'b1, 2'b11, 16'hBEEF, 4'd2, 3, 1, 1'b0);
    run_txn(26'h0AA_AAAA, 1'b1, 1'b0, 2'b10, 16'h1357, 4'd1, 0, 1, 1'b0);
    ready = 1'b0;
    run_txn(26'h012_3456, 1'b0, 1'b1, 2'b11, 16'h0, 4'd2, 1, 6, 1'b0);
    run_txn(26'h111_0000, 1'b0, 1'b0, 2'b00, 16'h0, 4'd2, 0, 1, 1'b0);
    run_txn(26'h2AB_CDEF, 1'b0, 1'b0, 2'b11, 16'h0, 4'd4, 1, 1, 1'b1);

    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      logic [1:0] ln;
      int ra;
      a  = AW'($urandom);
      ln = 2'($urandom_range(1, 3));
      ra = ($urandom_range(0, 3) == 0) ? int'($urandom_range(2, 5)) : 1;
      if (ra > 1) ready = 1'b0;
      run_txn(a, 1'($urandom), 1'($urandom), ln, 16'($urandom),
              LW'($urandom_range(0, 4)), int'($urandom_range(0, 3)), ra, 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule